// File: doc/BRIEF.md
# External I/O Read Strobe Sequencer

This block runs read accesses to up to four external I/O banks. A requester presents a bank index and an address. While the block is idle it accepts the request and steps through four timed phases. First the address is driven with chip select still high. Then chip select goes low while output enable stays high. Then output enable goes low for the access window. Last, chip select is held low after output enable has risen. The block then raises a one-cycle response pulse carrying the data it sampled from the external bus.

Each bank has four 3-bit phase lengths, taken from two 32-bit configuration words that the surrounding chip supplies as static inputs. A length of zero removes that phase from the sequence, so a bank can be set anywhere from the shortest possible access up to seven cycles per phase. The phase lengths and the address are captured when a request is accepted, so later changes to the inputs do not disturb a sequence already in flight.

The controller is a state machine with the states IDLE, ADDR_SETUP, CS_SETUP, ACCESS, HOLD and DONE. IDLE goes to the first phase with a non-zero length when a request arrives, or straight to DONE if every length is zero. Each phase state, once its counter has expired, goes to the next later phase with a non-zero length, or to DONE if none is left. DONE always returns to IDLE after one cycle.

Top module: `xio_strobe_seq`

## Requirements
- R1: After reset, req_ready is 1, io_cs_n and io_oe_n are 1, and rsp_valid is 0.
- R2: Bank b takes its lengths from the 16-bit half of cfg_timing that starts at bit 32*(b/2) + 16*(b%2). Within that half, the chip-select-to-output-enable setup length is at bits [2:0], the address setup length at [5:3], the chip select hold length at [8:6] and the access length at [11:9]. A field value n selects n cycles.
- R3: From the cycle after acceptance, io_addr carries the accepted address and keeps it for the whole sequence. For the first address-setup-length cycles, io_cs_n and io_oe_n are both 1.
- R4: io_cs_n then is 0 with io_oe_n at 1 for the setup-length cycles.
- R5: io_oe_n then is 0, with io_cs_n at 0, for exactly the access-length cycles.
- R6: io_cs_n then stays 0, with io_oe_n at 1, for the hold-length cycles, and returns to 1 afterwards.
- R7: A length field of 0 removes its phase. With all four fields at 0, the response comes in the cycle right after acceptance.
- R8: rsp_valid is 1 for exactly one cycle, the cycle after the last phase. rsp_data then holds io_rdata as it was in the last cycle of the access phase. If the access length is 0, rsp_data is 0.
- R9: req_ready is 0 from the cycle after acceptance through the response cycle. A request presented while req_ready is 0 is ignored: it does not change io_addr, and it starts no new sequence.
- R10: A change to cfg_timing after acceptance has no effect on the sequence already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_timing | input | 64 | Phase lengths for the four banks |
| req_valid | input | 1 | Read request |
| req_bank | input | 2 | Bank index of the request |
| req_addr | input | 24 | Address of the request |
| req_ready | output | 1 | Idle, able to accept a request |
| io_addr | output | 24 | External address |
| io_cs_n | output | 1 | Active-low chip select |
| io_oe_n | output | 1 | Active-low output enable |
| io_rdata | input | 16 | External read data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 16 | Data captured during the access phase |

## Verification
The assertions assume that req_valid, req_bank and req_addr are never unknown after reset. They also assume that a requester may hold req_valid high while the block is busy. That is legal input, and the block must ignore it rather than treat it as an error. The stimulus drives every input on the falling clock edge, always with defined values. It keeps a request high through a busy sequence on purpose, and it rewrites cfg_timing in the middle of a sequence, so that the ignore and capture rules are actually exercised.

// File: rtl/xio_pkg.sv
package xio_pkg;

    localparam int FLD_W     = 3;
    localparam int HALF_W    = 16;
    localparam int OFF_CSOE  = 0;
    localparam int OFF_ADDR  = 3;
    localparam int OFF_HOLD  = 6;
    localparam int OFF_ACC   = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_SETUP,
        ST_CS_SETUP,
        ST_ACCESS,
        ST_HOLD,
        ST_DONE
    } xio_state_e;

    typedef struct packed {
        logic [FLD_W-1:0] addr_len;
        logic [FLD_W-1:0] csoe_len;
        logic [FLD_W-1:0] acc_len;
        logic [FLD_W-1:0] hold_len;
    } xio_tim_t;

endpackage

// File: rtl/xio_cfg_decode.sv
module xio_cfg_decode
    import xio_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int BANK_W = 2
) (
    input  logic [((NBANK+1)/2)*32-1:0] cfg_timing,
    input  logic [BANK_W-1:0]           bank,
    output xio_tim_t                    tim
);

    xio_tim_t per_bank [NBANK];

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            localparam int BASE = (b / 2) * 32 + (b % 2) * HALF_W;
            assign per_bank[b].csoe_len = cfg_timing[BASE+OFF_CSOE +: FLD_W];
            assign per_bank[b].addr_len = cfg_timing[BASE+OFF_ADDR +: FLD_W];
            assign per_bank[b].hold_len = cfg_timing[BASE+OFF_HOLD +: FLD_W];
            assign per_bank[b].acc_len  = cfg_timing[BASE+OFF_ACC  +: FLD_W];
        end
    endgenerate

    always_comb begin
        tim = '0;
        for (int k = 0; k < NBANK; k++) begin
            if (bank == BANK_W'(k)) tim = per_bank[k];
        end
    end

endmodule

// File: rtl/xio_phase_next.sv
module xio_phase_next
    import xio_pkg::*;
(
    input  xio_state_e        cur,
    input  xio_tim_t          tim,
    output xio_state_e        nxt,
    output logic [FLD_W-1:0]  ld_val
);

    logic [FLD_W-1:0] lens [4];
    xio_state_e       phs  [4];
    int               start;
    logic             found;

    always_comb begin
        lens[0] = tim.addr_len;  phs[0] = ST_ADDR_SETUP;
        lens[1] = tim.csoe_len;  phs[1] = ST_CS_SETUP;
        lens[2] = tim.acc_len;   phs[2] = ST_ACCESS;
        lens[3] = tim.hold_len;  phs[3] = ST_HOLD;
        unique case (cur)
            ST_IDLE:       start = 0;
            ST_ADDR_SETUP: start = 1;
            ST_CS_SETUP:   start = 2;
            ST_ACCESS:     start = 3;
            default:       start = 4;
        endcase
        nxt    = ST_DONE;
        ld_val = '0;
        found  = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (k >= start && !found && lens[k] != '0) begin
                nxt    = phs[k];
                ld_val = lens[k] - FLD_W'(1);
                found  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/xio_phase_cnt.sv
module xio_phase_cnt #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] ld_val,
    input  logic          dec,
    output logic          zero
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= ld_val;
        else if (dec)  cnt <= cnt - CW'(1);
    end

    assign zero = (cnt == '0);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> !zero);  // R5

endmodule

// File: rtl/xio_strobe_seq.sv
module xio_strobe_seq
    import xio_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int BANK_W = 2,
    parameter int AW     = 24,
    parameter int DW     = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [((NBANK+1)/2)*32-1:0] cfg_timing,
    input  logic                        req_valid,
    input  logic [BANK_W-1:0]           req_bank,
    input  logic [AW-1:0]               req_addr,
    output logic                        req_ready,
    output logic [AW-1:0]               io_addr,
    output logic                        io_cs_n,
    output logic                        io_oe_n,
    input  logic [DW-1:0]               io_rdata,
    output logic                        rsp_valid,
    output logic [DW-1:0]               rsp_data
);

    xio_state_e       state, state_nx, pn_nxt;
    xio_tim_t         sel_tim, tim_q, pn_tim;
    logic [FLD_W-1:0] pn_ld;
    logic             cnt_zero, in_phase, accept, cnt_load, cnt_dec;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    data_q;

    xio_cfg_decode #(.NBANK(NBANK), .BANK_W(BANK_W)) u_dec (
        .cfg_timing (cfg_timing),
        .bank       (req_bank),
        .tim        (sel_tim)
    );

    assign pn_tim = (state == ST_IDLE) ? sel_tim : tim_q;

    xio_phase_next u_next (
        .cur    (state),
        .tim    (pn_tim),
        .nxt    (pn_nxt),
        .ld_val (pn_ld)
    );

    assign in_phase = (state == ST_ADDR_SETUP) || (state == ST_CS_SETUP) ||
                      (state == ST_ACCESS)     || (state == ST_HOLD);
    assign accept   = (state == ST_IDLE) && req_valid;
    assign cnt_load = accept || (in_phase && cnt_zero);
    assign cnt_dec  = in_phase && !cnt_zero;

    xio_phase_cnt #(.CW(FLD_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cnt_load),
        .ld_val (pn_ld),
        .dec    (cnt_dec),
        .zero   (cnt_zero)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (req_valid) state_nx = pn_nxt;
            ST_ADDR_SETUP,
            ST_CS_SETUP,
            ST_ACCESS,
            ST_HOLD:       if (cnt_zero)  state_nx = pn_nxt;
            ST_DONE:       state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // captured request, timing and read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            tim_q  <= '0;
            data_q <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
            tim_q  <= sel_tim;
            data_q <= '0;
        end else if (state == ST_ACCESS && cnt_zero) begin
            data_q <= io_rdata;
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        io_cs_n   = 1'b1;
        io_oe_n   = 1'b1;
        rsp_valid = 1'b0;
        unique case (state)
            ST_IDLE:       req_ready = 1'b1;
            ST_ADDR_SETUP: ;
            ST_CS_SETUP:   io_cs_n = 1'b0;
            ST_ACCESS: begin
                io_cs_n = 1'b0;
                io_oe_n = 1'b0;
            end
            ST_HOLD:       io_cs_n = 1'b0;
            ST_DONE:       rsp_valid = 1'b1;
            default:       ;
        endcase
    end

    assign io_addr  = addr_q;
    assign rsp_data = data_q;

    AST_OE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !io_oe_n |-> !io_cs_n);  // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (io_cs_n && io_oe_n && !rsp_valid));  // R1
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_ready)) |-> $stable(io_addr));  // R3
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));  // R8
    AST_RSP_STROBES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (io_cs_n && io_oe_n));  // R6
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !rsp_valid) |=> !req_ready);  // R9

endmodule

// File: tb/xio_strobe_seq_bench.sv
module xio_strobe_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cfg_timing = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [23:0] req_addr = '0;
    logic        req_ready;
    logic [23:0] io_addr;
    logic        io_cs_n, io_oe_n;
    logic [15:0] io_rdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    xio_strobe_seq u_xio_strobe_seq (
        .clk(clk), .rst_n(rst_n), .cfg_timing(cfg_timing),
        .req_valid(req_valid), .req_bank(req_bank), .req_addr(req_addr),
        .req_ready(req_ready), .io_addr(io_addr), .io_cs_n(io_cs_n),
        .io_oe_n(io_oe_n), .io_rdata(io_rdata), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // R2: field placement per bank
    task automatic set_bank(input int b, input int a, input int c, input int acc,
                            input int h);
        int base = (b / 2) * 32 + (b % 2) * 16;
        cfg_timing[base+0 +: 3] = 3'(c);
        cfg_timing[base+3 +: 3] = 3'(a);
        cfg_timing[base+6 +: 3] = 3'(h);
        cfg_timing[base+9 +: 3] = 3'(acc);
    endtask

    // mode 0 plain, 1 request held while busy (R9), 2 config rewritten mid-run (R10)
    task automatic run_access(input int b, input logic [23:0] addr, input int a,
                              input int c, input int acc, input int h,
                              input int mode, input string tag);
        int total = a + c + acc + h + 1;
        logic [15:0] exp_data = '0;
        logic [63:0] saved;
        @(negedge clk);
        req_valid = 1'b1; req_bank = 2'(b); req_addr = addr;
        for (int i = 1; i <= total; i++) begin
            @(negedge clk);
            if (i == 1) begin
                if (mode == 1) req_addr = addr ^ 24'h5A5A5A;
                else req_valid = 1'b0;
                if (mode == 2) begin saved = cfg_timing; cfg_timing = '1; end
            end
            if (i == total) req_valid = 1'b0;
            begin
                logic exp_cs, exp_oe;
                exp_cs = !(i > a && i <= a + c + acc + h);
                exp_oe = !(i > a + c && i <= a + c + acc);
                chk({req_ready, io_cs_n, io_oe_n, rsp_valid} ==
                    {1'b0, exp_cs, exp_oe, (i == total)},
                    {tag, " R3 R4 R5 R6 R9 strobes"},
                    {28'd0, req_ready, io_cs_n, io_oe_n, rsp_valid},
                    {28'd0, 1'b0, exp_cs, exp_oe, 1'(i == total)});
                chk(io_addr == addr, {tag, " R3 address"}, 32'(io_addr), 32'(addr));
                if (i == total)
                    chk(rsp_data == exp_data, {tag, " R8 data"}, 32'(rsp_data),
                        32'(exp_data));
            end
            io_rdata = 16'hA000 + 16'(i) + 16'(b << 8);
            if (acc != 0 && i == a + c + acc) exp_data = io_rdata;
        end
        if (mode == 2) cfg_timing = saved;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk({req_ready, io_cs_n, io_oe_n, rsp_valid} == 4'b1110,
                {tag, " R9 idle after"},
                {28'd0, req_ready, io_cs_n, io_oe_n, rsp_valid}, 32'hE);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk({req_ready, io_cs_n, io_oe_n, rsp_valid} == 4'b1110, "R1 reset",
            {28'd0, req_ready, io_cs_n, io_oe_n, rsp_valid}, 32'hE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        set_bank(0, 1, 1, 1, 1);
        set_bank(1, 2, 3, 4, 1);
        set_bank(2, 7, 1, 2, 5);
        set_bank(3, 0, 2, 0, 3);
        run_access(0, 24'h000100, 1, 1, 1, 1, 0, "bank0 R2");
        run_access(1, 24'h123456, 2, 3, 4, 1, 0, "bank1 R2");
        run_access(2, 24'hABCDEF, 7, 1, 2, 5, 0, "bank2 R2");
        run_access(3, 24'h0F0F0F, 0, 2, 0, 3, 0, "bank3 R7 R8");
        set_bank(3, 0, 0, 0, 0);
        run_access(3, 24'h777777, 0, 0, 0, 0, 0, "zero R7");
        set_bank(0, 3, 0, 7, 0);
        run_access(0, 24'h00BEEF, 3, 0, 7, 0, 0, "skip R7");
        run_access(1, 24'h222222, 2, 3, 4, 1, 1, "busy R9");
        run_access(2, 24'h333333, 7, 1, 2, 5, 2, "cfgchg R10");
        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule